// File: doc/BRIEF.md
# Self-Timed Non-Volatile Byte Store Controller

This block sits on the I/O bus of an 8-bit processor and gives software access to a 64-byte non-volatile byte array. Software sees three registers: a location register, a byte register and a command register. A read command copies the selected byte into the byte register. A write command starts a programming cycle that the block times itself. Software polls the command register to learn when the next byte may be written.

Each accepted command raises `cpu_hold` for a fixed number of clock cycles. This freezes the processor until the access has settled. While a command is in flight, further bus writes are dropped, so the location and the byte in use cannot be changed under it. The storage cells are modelled as a register array.

The sequencer has four named states. `ST_IDLE` accepts register writes and commands. `ST_RD_LOAD` loads the byte register from the array. `ST_RD_CLEAR` holds the read flag for one further cycle. `ST_PROG` waits for the programming timer. The transitions are:
- idle-to-read: a command write with bit 0 set and bit 1 clear.
- read-load-to-read-clear: always taken after one cycle.
- read-clear-to-idle: always taken after one cycle.
- idle-to-program: a command write with bit 1 set.
- program-to-idle: the timer expires; the byte is stored on this same transition.

Top module: `nvbyte_access_ctrl`

## Requirements
- R1: After reset the location, byte and command registers all read 0x00, `cpu_hold` is low and every array byte is 0x00.
- R2: The location register (I/O select 0x1E) stores bits 5..0 of the written value. Bits 7..6 always read as zero.
- R3: The command register is at select 0x1C. It reads bit 1 as the write-busy flag and bit 0 as the read flag, and bits 7..2 read as zero. A command write with neither bit set starts nothing. Any select other than 0x1E, 0x1D or 0x1C reads 0x00.
- R4: Writing 1 to bit 0 of the command register (bit 1 clear) in `ST_IDLE` starts a read. The read flag reads 1 for the two cycles after the command edge and 0 after that. From the second cycle on, the byte register (select 0x1D) holds the array byte at the current location.
- R5: Writing 1 to bit 1 of the command register in `ST_IDLE` starts a write. The write-busy flag reads 1 for exactly PROG_CYCLES cycles after the command edge and then clears by itself. At that clearing, the byte register value is stored at the current location.
- R6: `cpu_hold` is high for exactly HOLD_CYCLES (default 2) cycles after each accepted command edge, and is low otherwise.
- R7: Outside `ST_IDLE`, bus writes to the location, byte and command registers have no effect. A command issued then raises no hold, and the location and byte written then are not taken.
- R8: A command write with bits 1 and 0 both set starts only the write. The read flag stays 0.
- R9: In `ST_IDLE` the byte register (select 0x1D) takes the bus value and reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_sel | input | 6 | I/O register select |
| io_we | input | 1 | Bus write strobe for the selected register |
| io_wdata | input | 8 | Bus write value |
| io_rdata | output | 8 | Read-back value of the selected register |
| cpu_hold | output | 1 | Processor stall request |

## Verification
The bench builds the block with PROG_CYCLES set to 20 and HOLD_CYCLES left at 2. With these values every cycle of a programming window can be checked one by one, along with the exact cycle in which the busy flag drops. The short window also makes it practical to aim bus writes and a stray read command at the first cycles of a busy period, and to read back later the bytes that a write and a combined write-and-read command stored.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_LOAD  = 2'd1,
        ST_RD_CLEAR = 2'd2,
        ST_PROG     = 2'd3
    } nvb_state_t;

endpackage

// File: rtl/nvb_array.sv
module nvb_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] loc,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [DATA_W-1:0] rd_byte
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[loc] <= wr_byte;
        end
    end

    assign rd_byte = cells[loc];

endmodule

// File: rtl/nvb_prog_timer.sv
module nvb_prog_timer #(
    parameter int PROG_CYCLES = 36000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CNT_W'(PROG_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == CNT_W'(1));

    // R5: the count never jumps while it runs
    assert_timer_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (remain > CNT_W'(1) && !start) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/nvb_hold_gen.sv
module nvb_hold_gen #(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic hold
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left <= '0;
        end else if (trig) begin
            left <= CNT_W'(HOLD_CYCLES);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign hold = (left != '0);

    assert_hold_follows_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> hold);

endmodule

// File: rtl/nvbyte_access_ctrl.sv
module nvbyte_access_ctrl #(
    parameter int         ADDR_W      = 6,
    parameter int         DATA_W      = 8,
    parameter int         SEL_W       = 6,
    parameter logic [5:0] LOC_ADDR    = 6'h1E,
    parameter logic [5:0] LOC_DATA    = 6'h1D,
    parameter logic [5:0] LOC_CTRL    = 6'h1C,
    parameter int         PROG_CYCLES = 36000,
    parameter int         HOLD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  io_sel,
    input  logic              io_we,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              cpu_hold
);
    import nvb_pkg::*;

    localparam int WE_BIT = 1;
    localparam int RE_BIT = 0;
    localparam int PAD_W  = DATA_W - ADDR_W;

    nvb_state_t        state_q, state_nx;
    logic [ADDR_W-1:0] loc_q;
    logic [DATA_W-1:0] byte_q;
    logic [DATA_W-1:0] cell_rd;
    logic              in_idle, hit_loc, hit_byte, hit_cmd;
    logic              start_wr, start_rd, prog_done;
    logic              busy_flag, read_flag;

    assign in_idle  = (state_q == ST_IDLE);
    assign hit_loc  = io_we && (io_sel == LOC_ADDR);
    assign hit_byte = io_we && (io_sel == LOC_DATA);
    assign hit_cmd  = io_we && (io_sel == LOC_CTRL);
    assign start_wr = in_idle && hit_cmd && io_wdata[WE_BIT];
    assign start_rd = in_idle && hit_cmd && io_wdata[RE_BIT] && !io_wdata[WE_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr)      state_nx = ST_PROG;
                else if (start_rd) state_nx = ST_RD_LOAD;
            end
            ST_RD_LOAD:  state_nx = ST_RD_CLEAR;
            ST_RD_CLEAR: state_nx = ST_IDLE;
            ST_PROG:     if (prog_done) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // location and byte registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc_q  <= '0;
            byte_q <= '0;
        end else begin
            if (in_idle && hit_loc) loc_q <= io_wdata[ADDR_W-1:0];
            if (in_idle && hit_byte)            byte_q <= io_wdata;
            else if (state_q == ST_RD_LOAD)     byte_q <= cell_rd;
        end
    end

    // outputs
    always_comb begin
        busy_flag = (state_q == ST_PROG);
        read_flag = (state_q == ST_RD_LOAD) || (state_q == ST_RD_CLEAR);
        io_rdata  = '0;
        if (io_sel == LOC_ADDR)      io_rdata = {{PAD_W{1'b0}}, loc_q};
        else if (io_sel == LOC_DATA) io_rdata = byte_q;
        else if (io_sel == LOC_CTRL) io_rdata = {{(DATA_W-2){1'b0}}, busy_flag, read_flag};
    end

    nvb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (busy_flag && prog_done),
        .loc     (loc_q),
        .wr_byte (byte_q),
        .rd_byte (cell_rd)
    );

    nvb_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_wr),
        .done  (prog_done)
    );

    nvb_hold_gen #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (start_wr || start_rd),
        .hold  (cpu_hold)
    );

    assert_loc_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel == LOC_ADDR) |-> (io_rdata[DATA_W-1:ADDR_W] == '0));

    assert_read_flag_two_cycles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_flag) |=> read_flag ##1 !read_flag);

    assert_busy_until_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_flag && !prog_done) |=> busy_flag);

    assert_frozen_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_flag |=> ($stable(loc_q) && $stable(byte_q)));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && hit_cmd && io_wdata[WE_BIT] && io_wdata[RE_BIT]) |=> (busy_flag && !read_flag));

endmodule

// File: tb/nvbyte_access_ctrl_bench.sv
module nvbyte_access_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 20;
    localparam logic [5:0] S_LOC  = 6'h1E;
    localparam logic [5:0] S_BYTE = 6'h1D;
    localparam logic [5:0] S_CMD  = 6'h1C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] io_sel = '0;
    logic       io_we = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       cpu_hold;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] exp_rd_q [$];
    logic       exp_hold_q [$];
    string      req_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvbyte_access_ctrl #(.PROG_CYCLES(PROG), .HOLD_CYCLES(2)) u_nvbyte_access_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_sel   (io_sel),
        .io_we    (io_we),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .cpu_hold (cpu_hold)
    );

    // driver tasks: each starts and ends on a falling edge
    task automatic wr(input logic [5:0] sel, input logic [7:0] val);
        io_sel = sel; io_wdata = val; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic chk(input logic [5:0] sel, input logic [7:0] rd,
                       input logic hold, input string req);
        io_sel = sel;
        exp_rd_q.push_back(rd);
        exp_hold_q.push_back(hold);
        req_q.push_back(req);
        @(negedge clk);
    endtask

    // monitor: compares one cycle after the driver set up the select
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_rd_q.size() > 0) begin
                logic [7:0] e_rd;
                logic       e_hold;
                string      r;
                e_rd = exp_rd_q.pop_front();
                e_hold = exp_hold_q.pop_front();
                r = req_q.pop_front();
                checks++;
                if (io_rdata !== e_rd || cpu_hold !== e_hold) begin
                    errors++;
                    $display("FAIL %s: rdata=%02h hold=%0b expected rdata=%02h hold=%0b",
                             r, io_rdata, cpu_hold, e_rd, e_hold);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(S_LOC, 8'h00, 1'b0, "R1");
        chk(S_BYTE, 8'h00, 1'b0, "R1");
        chk(S_CMD, 8'h00, 1'b0, "R1");
        wr(S_LOC, 8'h3F);
        wr(S_CMD, 8'h01);
        chk(S_CMD, 8'h01, 1'b1, "R1_read_init");
        chk(S_CMD, 8'h01, 1'b1, "R1_read_init");
        chk(S_BYTE, 8'h00, 1'b0, "R1 array zero");

        // R2 padding bits
        wr(S_LOC, 8'hFF);
        chk(S_LOC, 8'h3F, 1'b0, "R2");
        wr(S_LOC, 8'hC5);
        chk(S_LOC, 8'h05, 1'b0, "R2");

        // R3 reserved command bits and unmapped selects
        wr(S_CMD, 8'hFC);
        chk(S_CMD, 8'h00, 1'b0, "R3");
        chk(6'h10, 8'h00, 1'b0, "R3 unmapped");

        // R9 byte register
        wr(S_BYTE, 8'hA5);
        chk(S_BYTE, 8'hA5, 1'b0, "R9");

        // R5 write to location 5, R6 hold during it
        wr(S_CMD, 8'h02);
        for (int k = 1; k <= PROG; k++) begin
            chk(S_CMD, 8'h02, (k <= 2), (k <= 2) ? "R6" : "R5");
        end
        chk(S_CMD, 8'h00, 1'b0, "R5 busy clears");

        // R7 bus writes during programming
        wr(S_LOC, 8'h09);
        wr(S_BYTE, 8'h3C);
        wr(S_CMD, 8'h02);
        wr(S_LOC, 8'h3F);
        wr(S_BYTE, 8'hFF);
        wr(S_CMD, 8'h01);
        for (int k = 4; k <= PROG; k++) begin
            chk(S_CMD, 8'h02, 1'b0, "R7");
        end
        chk(S_CMD, 8'h00, 1'b0, "R5");
        chk(S_LOC, 8'h09, 1'b0, "R7 location kept");
        chk(S_BYTE, 8'h3C, 1'b0, "R7 byte kept");

        // R4 read back location 5, R7 write during read ignored
        wr(S_LOC, 8'h05);
        wr(S_CMD, 8'h01);
        io_sel = S_BYTE; io_wdata = 8'h77; io_we = 1'b1;
        exp_rd_q.push_back(8'h3C); exp_hold_q.push_back(1'b1); req_q.push_back("R4 before load");
        @(negedge clk);
        io_we = 1'b0;
        chk(S_BYTE, 8'hA5, 1'b1, "R4 loaded");
        chk(S_CMD, 8'h00, 1'b0, "R4 flag cleared");
        chk(S_BYTE, 8'hA5, 1'b0, "R7 byte during read");

        // R4 read back location 9
        wr(S_LOC, 8'h09);
        wr(S_CMD, 8'h01);
        chk(S_CMD, 8'h01, 1'b1, "R4");
        chk(S_CMD, 8'h01, 1'b1, "R4");
        chk(S_BYTE, 8'h3C, 1'b0, "R4 stored byte");

        // R8 both command bits
        wr(S_LOC, 8'h07);
        wr(S_BYTE, 8'h5A);
        wr(S_CMD, 8'h03);
        chk(S_CMD, 8'h02, 1'b1, "R8");
        for (int k = 2; k <= PROG; k++) begin
            chk(S_CMD, 8'h02, (k <= 2), "R8");
        end
        chk(S_CMD, 8'h00, 1'b0, "R8");
        wr(S_BYTE, 8'h00);
        wr(S_CMD, 8'h01);
        @(negedge clk);
        @(negedge clk);
        chk(S_BYTE, 8'h5A, 1'b0, "R8 byte stored");

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule